// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block arbitrates three interrupt sources for a small processor core: a periodic time base, an overflow from timer 0 and an overflow from timer 1. One 8-bit control word holds a master enable, an enable for each source and a pending flag for each source. Software reads and writes the whole word. Source events latch their pending flags. The core can only take an interrupt at the boundary of an instruction cycle. A phase strobe marks that boundary.

When the strobe arrives, the block looks at the pending flags. A source is serviced when the master enable is on, the source's own enable is on, its flag is set and the hardware return stack has room. In that case the block raises a one-cycle call request and presents that source's fixed vector address. The same acknowledge clears the serviced flag and the master enable, so no second interrupt can nest. The master enable comes back on only when the core signals a return-from-interrupt, or when software writes it. An ordinary subroutine return has no strobe into this block and therefore never re-enables interrupts.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the control word reads 0x00 and no call is requested. The readback layout is bit0 master enable, bit1 time-base enable, bit2 timer-0 enable, bit3 timer-1 enable, bit4 time-base flag, bit5 timer-0 flag and bit6 timer-1 flag. Bit7 always reads 0, even after a write of 1.
- R2: An event pulse on a source (evt_i bit0 time base, bit1 timer 0, bit2 timer 1) sets that source's flag. Software may also set or clear a flag by writing it. A flag stays set until it is serviced or overwritten by software.
- R3: If an event and a clearing of the same flag happen in the same cycle, the event wins and the flag ends set. The clearing may come from a software write or from a hardware acknowledge.
- R4: A source is serviced only when four conditions hold together: the master enable is set, the source's enable is set, the source's flag is set and stack_full_i is low. Otherwise no call is made and the flag is kept.
- R5: Pending flags are evaluated only in a cycle where phase_i is high. A request that arrives between two strobes is serviced at the later strobe. An event in the same cycle as a strobe waits for the next strobe.
- R6: When several sources qualify at once, the time base is served first, then timer 0, then timer 1. The vectors are 0x04, 0x08 and 0x0C respectively.
- R7: call_o is high for exactly one cycle, the cycle after the qualifying strobe. vector_o holds the served vector during that cycle. The served flag and the master enable read back as 0 from that cycle on.
- R8: Only reti_i or a register write sets the master enable again. If an acknowledge and reti_i occur in the same cycle, the acknowledge wins and the master enable ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 3 | Source event pulses (bit0 time base, bit1 timer 0, bit2 timer 1) |
| stack_full_i | input | 1 | Return stack has no free entry |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 8 | Write data for the control word |
| reg_rdata_o | output | 8 | Current control word |
| reti_i | input | 1 | Return-from-interrupt strobe |
| phase_i | input | 1 | Instruction-cycle boundary strobe |
| call_o | output | 1 | One-cycle subroutine call request |
| vector_o | output | 8 | Vector address of the served source |

## Verification
The bench raises all three sources together and then re-arms with reti_i. A design with a reversed priority would serve timer 1 first, and one that never cleared the master enable would serve all three sources from back-to-back strobes. The bench holds flags pending with the stack full and with the master enable off. A wrong gating term would make a call the core cannot take, or would drop the request for good. It also fires an event in the same cycle as a flag clear or an acknowledge. A design that applied the clear last would lose that interrupt. Finally, it raises an event in the strobe cycle itself. A design that sampled the event without a register would answer one boundary early.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Vector address of source idx: sources sit step bytes apart, starting one step above zero.
  function automatic logic [15:0] vec_addr(input int idx, input int step);
    vec_addr = 16'((idx + 1) * step);
  endfunction

  // Lowest-index set bit wins: returns a one-hot mask (or zero).
  function automatic logic [15:0] first_set(input logic [15:0] req);
    first_set = '0;
    for (int i = 15; i >= 0; i--) begin
      if (req[i]) first_set = 16'(1) << i;
    end
  endfunction

endpackage

// File: rtl/irqv_ctrl_reg.sv
module irqv_ctrl_reg #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            wr_master,
  input  logic [NSRC-1:0] wr_en,
  input  logic [NSRC-1:0] wr_flag,
  input  logic [NSRC-1:0] evt,
  input  logic            ack,
  input  logic [NSRC-1:0] ack_sel,
  input  logic            reti,
  output logic            master,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flag
);

  logic            master_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] flag_base;   // flag after software write and ack clear
  logic [NSRC-1:0] flag_d;
  logic            master_d;

  always_comb begin
    flag_base = we ? wr_flag : flag_q;
    if (ack) flag_base = flag_base & ~ack_sel;
    flag_d = flag_base | evt;    // event dominates any clear
  end

  always_comb begin
    if (ack)       master_d = 1'b0;
    else if (reti) master_d = 1'b1;
    else if (we)   master_d = wr_master;
    else           master_d = master_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      en_q     <= '0;
      flag_q   <= '0;
    end else begin
      master_q <= master_d;
      if (we) en_q <= wr_en;
      flag_q   <= flag_d;
    end
  end

  assign master = master_q;
  assign en     = en_q;
  assign flag   = flag_q;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_flag_chk
      // R2 R3
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[g] |=> flag_q[g]);
    end
  endgenerate

  // R8
  ack_clears_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !master_q);

  // R8
  master_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_q) |-> $past(reti) || $past(we));

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int NSRC = 3
) (
  input  logic            master,
  input  logic            stack_full,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] flag,
  output logic [NSRC-1:0] grant,
  output logic            any_req
);
  import irqv_pkg::*;

  logic [NSRC-1:0] req;
  logic [15:0]     pick;

  assign req     = (master && !stack_full) ? (en & flag) : '0;
  assign pick    = first_set(16'(req));
  assign grant   = pick[NSRC-1:0];
  assign any_req = |req;

  // R6
  grant_onehot_chk: assert final ($onehot0(grant));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC     = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4,
  localparam int REG_W   = 2 * NSRC + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  evt_i,
  input  logic             stack_full_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             reti_i,
  input  logic             phase_i,
  output logic             call_o,
  output logic [VEC_W-1:0] vector_o
);
  import irqv_pkg::*;

  logic            master;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] flag;
  logic [NSRC-1:0] grant;
  logic            any_req;
  logic            ack;          // named event: service taken at this boundary
  logic [VEC_W-1:0] grant_vec;
  logic            call_q;
  logic [VEC_W-1:0] vec_q;
  logic            wdata_unused;

  assign wdata_unused = reg_wdata_i[REG_W-1];

  irqv_ctrl_reg #(.NSRC(NSRC)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we_i),
    .wr_master (reg_wdata_i[0]),
    .wr_en     (reg_wdata_i[NSRC:1]),
    .wr_flag   (reg_wdata_i[2*NSRC:NSRC+1]),
    .evt       (evt_i),
    .ack       (ack),
    .ack_sel   (grant),
    .reti      (reti_i),
    .master    (master),
    .en        (en),
    .flag      (flag)
  );

  irqv_arbiter #(.NSRC(NSRC)) u_arb (
    .master     (master),
    .stack_full (stack_full_i),
    .en         (en),
    .flag       (flag),
    .grant      (grant),
    .any_req    (any_req)
  );

  assign ack = phase_i && any_req;

  always_comb begin
    grant_vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) grant_vec = VEC_W'(vec_addr(i, VEC_STEP));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      call_q <= ack;
      if (ack) vec_q <= grant_vec;
    end
  end

  assign call_o      = call_q;
  assign vector_o    = vec_q;
  assign reg_rdata_o = {1'b0, flag, en, master};

  // R7
  call_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |=> !call_o);

  // R5
  call_on_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> $past(phase_i));

  // R4
  stack_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i && stack_full_i) |=> !call_o);

  // R7
  call_master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> !reg_rdata_o[0]);

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt_i = '0;
  logic       stack_full_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       reti_i = 1'b0;
  logic       phase_i = 1'b0;
  logic       call_o;
  logic [7:0] vector_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .stack_full_i(stack_full_i),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .reti_i(reti_i), .phase_i(phase_i), .call_o(call_o), .vector_o(vector_o)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we_i = 1'b1; reg_wdata_i = v; cyc(); reg_we_i = 1'b0;
  endtask

  task automatic fire(input logic [2:0] m);
    evt_i = m; cyc(); evt_i = '0;
  endtask

  task automatic strobe();
    phase_i = 1'b1; cyc(); phase_i = 1'b0;
  endtask

  task automatic do_reti();
    reti_i = 1'b1; cyc(); reti_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "reset word", reg_rdata_o, 8'h00);
    chk("R1", "reset call", call_o, 0);
    wr(8'hFF);
    chk("R1", "bit7 reads 0", reg_rdata_o, 8'h7F);
    wr(8'h00);
    chk("R1", "cleared word", reg_rdata_o, 8'h00);
  endtask

  task automatic t_basic();
    wr(8'h05);
    fire(3'b010);
    chk("R2", "timer0 flag set", reg_rdata_o, 8'h25);
    cyc(); cyc();
    chk("R2", "flag holds", reg_rdata_o, 8'h25);
    strobe();
    chk("R7", "call raised", call_o, 1);
    chk("R6", "timer0 vector", vector_o, 8'h08);
    chk("R7", "flag and master cleared", reg_rdata_o, 8'h04);
    cyc();
    chk("R7", "call one cycle", call_o, 0);
    chk("R7", "vector held", vector_o, 8'h08);
  endtask

  task automatic t_priority();
    wr(8'h0F);
    fire(3'b111);
    strobe();
    chk("R6", "time base first", vector_o, 8'h04);
    chk("R6", "after tb", reg_rdata_o, 8'h6E);
    strobe();
    chk("R8", "no call without reti", call_o, 0);
    do_reti();
    chk("R8", "reti sets master", reg_rdata_o, 8'h6F);
    strobe();
    chk("R6", "timer0 second", vector_o, 8'h08);
    chk("R6", "call second", call_o, 1);
    do_reti();
    strobe();
    chk("R6", "timer1 third", vector_o, 8'h0C);
    chk("R6", "all flags gone", reg_rdata_o, 8'h0E);
  endtask

  task automatic t_stack();
    wr(8'h03);
    fire(3'b001);
    stack_full_i = 1'b1;
    strobe();
    chk("R4", "stack full blocks", call_o, 0);
    chk("R4", "flag kept", reg_rdata_o, 8'h13);
    stack_full_i = 1'b0;
    strobe();
    chk("R4", "served after room", call_o, 1);
    chk("R4", "tb vector", vector_o, 8'h04);
  endtask

  task automatic t_gating();
    wr(8'h01);
    fire(3'b100);
    strobe();
    chk("R4", "source disabled", call_o, 0);
    chk("R4", "flag pending", reg_rdata_o, 8'h41);
    wr(8'h1E);
    strobe();
    chk("R4", "master off", call_o, 0);
    chk("R2", "software set flag", reg_rdata_o, 8'h1E);
    wr(8'h1F);
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R5", "no strobe no call", call_o, 0);
    end
    strobe();
    chk("R5", "later strobe serves", call_o, 1);
  endtask

  task automatic t_race();
    wr(8'h20);
    reg_we_i = 1'b1; reg_wdata_i = 8'h00; evt_i = 3'b010; cyc();
    reg_we_i = 1'b0; evt_i = '0;
    chk("R3", "event beats sw clear", reg_rdata_o, 8'h20);
    wr(8'h00);
    chk("R2", "sw clear alone", reg_rdata_o, 8'h00);
    wr(8'h13);
    phase_i = 1'b1; evt_i = 3'b001; cyc(); phase_i = 1'b0; evt_i = '0;
    chk("R3", "event beats ack clear", reg_rdata_o, 8'h12);
    chk("R3", "ack took place", call_o, 1);
    wr(8'h03);
    phase_i = 1'b1; evt_i = 3'b001; cyc(); phase_i = 1'b0; evt_i = '0;
    chk("R5", "same-cycle event waits", call_o, 0);
    strobe();
    chk("R5", "next strobe serves", call_o, 1);
    wr(8'h13);
    phase_i = 1'b1; reti_i = 1'b1; cyc(); phase_i = 1'b0; reti_i = 1'b0;
    chk("R8", "ack beats reti", reg_rdata_o, 8'h02);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_basic();
    t_priority();
    t_stack();
    t_gating();
    t_race();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule